// File: doc/BRIEF.md
# Lane-Rate PHY Test-Port Programmer

This block sets the lane-rate band of a serial camera receiver PHY. The PHY exposes a narrow test port for this: a clear line, a strobe, an address/data select line and an 8-bit bus. The sequencer takes the requested data-lane bit rate in MHz and a one-cycle start pulse. That rate is the per-lane bit rate, which is twice the clock-lane frequency because data moves on both clock edges. The sequencer finds the band that contains the rate and latches the bus code for that band. It then drives the port through a fixed series of steps: a clear pulse, an address write of the lane-rate register, and a data write of the code.

Each port level is held for `HOLD_CYC` system clocks, so the setup and hold times around the strobe come from one parameter. A rate outside the supported span does not touch the port. Instead the block raises a one-cycle error pulse. Start, rate, busy, done and error are plain control and status pins. There is no valid/ready stream and no back-pressure. A start pulse is acted on only while busy is low, and any other start pulse is dropped.

Top module: `lrp_rate_prog`

## Requirements
- R1: Bands use an inclusive lower bound and an exclusive upper bound, in MHz. Each band maps to a bus code, listed here in rising rate order: [80,90)=0x00, [90,100)=0x20, [100,110)=0x40, [110,125)=0x02, [125,140)=0x22, [140,150)=0x42, [150,160)=0x04, [160,180)=0x24, [180,200)=0x44, [200,210)=0x06, [210,240)=0x26, [240,250)=0x46, [250,270)=0x08, [270,300)=0x28, [300,330)=0x48, [330,360)=0x2A, [360,400)=0x4A, [400,450)=0x0C, [450,500)=0x2C, [500,550)=0x0E, [550,600)=0x2E, [600,650)=0x10, [650,700)=0x30, [700,750)=0x12, [750,800)=0x32, [800,850)=0x14, [850,900)=0x34, [900,950)=0x54, [950,1000)=0x74.
- R2: The first step of a sequence drives port_clr=1 with port_bus=0, port_strobe=0 and port_addr_mode=0. The next step releases port_clr and leaves every port output low. port_clr never rises again after a strobe has been issued.
- R3: The first write is the address phase. During this phase port_addr_mode=1 and port_bus=0x44 (ADDR_CODE), and port_strobe goes low, then high, then low. port_bus does not change while port_strobe is high.
- R4: The second write is the data phase. During this phase port_addr_mode=0 and port_bus carries the R1 code of the rate that was present when start was accepted, and port_strobe goes low, then high, then low. A change of rate_mhz after acceptance has no effect.
- R5: Each of the eight port steps (clear high, clear low, address setup, address strobe, address end, data setup, data strobe, data end) is held for exactly HOLD_CYC clocks, where HOLD_CYC is at least 2. Each strobe is therefore high for HOLD_CYC clocks.
- R6: busy rises on the clock edge that accepts start and stays high for 8*HOLD_CYC cycles. busy then falls, and in that same cycle done is high for exactly one cycle.
- R7: A start pulse is accepted only while busy is low, which includes the done cycle. A start pulse that arrives while busy is high is ignored: it does not restart the sequence and does not change the code.
- R8: A start with rate_mhz below 80 or at or above 1000 produces a one-cycle err pulse on the next cycle. It drives no port activity and produces no busy and no done.
- R9: A synchronous reset (rst=1) returns the block to idle. On the next cycle busy, done and err are low, all port outputs are low, and port_bus is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to program the PHY |
| rate_mhz | input | RATE_W | Requested data-lane bit rate in MHz |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when a sequence completes |
| err | output | 1 | One-cycle pulse when a rate is rejected |
| port_clr | output | 1 | PHY test-port clear line |
| port_strobe | output | 1 | PHY test-port strobe |
| port_addr_mode | output | 1 | High for an address write, low for a data write |
| port_bus | output | BUS_W | PHY test-port data bus |

## Verification
The bench steps rate_mhz onto both sides of several band edges, including the non-monotonic steps such as 109 to 110, where the code falls from 0x40 to 0x02. An off-by-one comparison would show up as the code of the neighbouring band. The values 79, 1000 and full scale probe the rejection span; a design that got this wrong would strobe the PHY with a stale or zero code instead of pulsing err. A start pulse with a new rate is injected in the middle of a sequence. This catches a design that restarts, or that relatches the code, which would show up as an extra busy window or a wrong data byte. Further tests cover a restart in the done cycle and a reset during the address phase, which must leave the port fully low on the next cycle.

// File: rtl/lrp_pkg.sv
package lrp_pkg;

  localparam int NUM_BANDS = 29;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CLR_HI,
    ST_CLR_LO,
    ST_A_SET,
    ST_A_STB,
    ST_A_END,
    ST_D_SET,
    ST_D_STB,
    ST_D_END,
    ST_DONE
  } step_e;

  // Lower edge (inclusive) of each band in MHz; index NUM_BANDS gives the
  // exclusive top of the last band.
  function automatic int unsigned band_lo(input int unsigned idx);
    case (idx)
      0:  return 80;
      1:  return 90;
      2:  return 100;
      3:  return 110;
      4:  return 125;
      5:  return 140;
      6:  return 150;
      7:  return 160;
      8:  return 180;
      9:  return 200;
      10: return 210;
      11: return 240;
      12: return 250;
      13: return 270;
      14: return 300;
      15: return 330;
      16: return 360;
      17: return 400;
      18: return 450;
      19: return 500;
      20: return 550;
      21: return 600;
      22: return 650;
      23: return 700;
      24: return 750;
      25: return 800;
      26: return 850;
      27: return 900;
      28: return 950;
      default: return 1000;
    endcase
  endfunction

  // Bus code for each band, already in its on-bus (shifted) form.
  function automatic logic [7:0] band_code(input int unsigned idx);
    case (idx)
      0:  return 8'h00;
      1:  return 8'h20;
      2:  return 8'h40;
      3:  return 8'h02;
      4:  return 8'h22;
      5:  return 8'h42;
      6:  return 8'h04;
      7:  return 8'h24;
      8:  return 8'h44;
      9:  return 8'h06;
      10: return 8'h26;
      11: return 8'h46;
      12: return 8'h08;
      13: return 8'h28;
      14: return 8'h48;
      15: return 8'h2A;
      16: return 8'h4A;
      17: return 8'h0C;
      18: return 8'h2C;
      19: return 8'h0E;
      20: return 8'h2E;
      21: return 8'h10;
      22: return 8'h30;
      23: return 8'h12;
      24: return 8'h32;
      25: return 8'h14;
      26: return 8'h34;
      27: return 8'h54;
      28: return 8'h74;
      default: return 8'h00;
    endcase
  endfunction

  function automatic step_e step_after(input step_e cur);
    case (cur)
      ST_CLR_HI: return ST_CLR_LO;
      ST_CLR_LO: return ST_A_SET;
      ST_A_SET:  return ST_A_STB;
      ST_A_STB:  return ST_A_END;
      ST_A_END:  return ST_D_SET;
      ST_D_SET:  return ST_D_STB;
      ST_D_STB:  return ST_D_END;
      ST_D_END:  return ST_DONE;
      default:   return ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/lrp_band_lookup.sv
module lrp_band_lookup
  import lrp_pkg::*;
#(
  parameter int RATE_W = 11,
  parameter int BUS_W  = 8
) (
  input  logic [RATE_W-1:0] rate,
  output logic              in_band,
  output logic [BUS_W-1:0]  code
);

  localparam int unsigned SPAN_LO = band_lo(0);
  localparam int unsigned SPAN_HI = band_lo(NUM_BANDS);

  logic [31:0]          rate32;
  logic [NUM_BANDS-1:0] hit;

  assign rate32 = 32'(rate);

  for (genvar g = 0; g < NUM_BANDS; g++) begin : g_band
    localparam logic [31:0] LO = 32'(band_lo(g));
    localparam logic [31:0] HI = 32'(band_lo(g + 1));
    assign hit[g] = (rate32 >= LO) && (rate32 < HI);
  end

  always_comb begin
    code = '0;
    for (int i = 0; i < NUM_BANDS; i++) begin
      if (hit[i]) code = code | BUS_W'(band_code(i));
    end
  end

  assign in_band = |hit;

  // R1: bands never overlap, and the band set covers exactly the legal span
  always_comb begin
    a_r1_single_band: assert ($onehot0(hit));
    a_r1_span_cover: assert (in_band == ((rate32 >= SPAN_LO) && (rate32 < SPAN_HI)));
  end

endmodule

// File: rtl/lrp_hold_timer.sv
module lrp_hold_timer #(
  parameter int HOLD_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic last
);

  localparam int CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(HOLD_CYC - 1);

  logic [CNT_W-1:0] cnt;

  assign last = run && (cnt == CNT_TOP);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (last)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  // R5: each fresh run of steps starts its hold count from zero
  a_r5_hold_restart: assert property (@(posedge clk) disable iff (rst)
    (run && !$past(run)) |-> (cnt == '0));

endmodule

// File: rtl/lrp_step_fsm.sv
module lrp_step_fsm
  import lrp_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             band_ok,
  input  logic [BUS_W-1:0] band_code,
  input  logic             step_last,
  output step_e            state,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [BUS_W-1:0] code_q
);

  assign busy = !(state == ST_IDLE || state == ST_DONE);
  assign done = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      code_q <= '0;
      err    <= 1'b0;
    end else begin
      err <= 1'b0;
      if (!busy) begin
        if (start && band_ok) begin
          state  <= ST_CLR_HI;
          code_q <= band_code;
        end else begin
          state <= ST_IDLE;
          if (start) err <= 1'b1;
        end
      end else if (step_last) begin
        state <= step_after(state);
      end
    end
  end

  // R4: the latched code cannot move while a sequence runs
  a_r4_code_held: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(code_q));

  // R6: done is a single-cycle pulse
  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: start while busy does not disturb the current step
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !step_last) |=> $stable(state));

endmodule

// File: rtl/lrp_port_drive.sv
module lrp_port_drive
  import lrp_pkg::*;
#(
  parameter int                BUS_W     = 8,
  parameter logic [BUS_W-1:0]  ADDR_CODE = 'h44
) (
  input  step_e            state,
  input  logic [BUS_W-1:0] code_q,
  output logic             p_clr,
  output logic             p_strobe,
  output logic             p_addr_mode,
  output logic [BUS_W-1:0] p_bus
);

  always_comb begin
    p_clr       = 1'b0;
    p_strobe    = 1'b0;
    p_addr_mode = 1'b0;
    p_bus       = '0;
    case (state)
      ST_CLR_HI: p_clr = 1'b1;
      ST_A_SET, ST_A_END: begin
        p_addr_mode = 1'b1;
        p_bus       = ADDR_CODE;
      end
      ST_A_STB: begin
        p_addr_mode = 1'b1;
        p_bus       = ADDR_CODE;
        p_strobe    = 1'b1;
      end
      ST_D_SET, ST_D_END: p_bus = code_q;
      ST_D_STB: begin
        p_bus    = code_q;
        p_strobe = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/lrp_rate_prog.sv
module lrp_rate_prog
  import lrp_pkg::*;
#(
  parameter int               RATE_W    = 11,
  parameter int               BUS_W     = 8,
  parameter int               HOLD_CYC  = 4,
  parameter logic [BUS_W-1:0] ADDR_CODE = 'h44
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [RATE_W-1:0] rate_mhz,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              port_clr,
  output logic              port_strobe,
  output logic              port_addr_mode,
  output logic [BUS_W-1:0]  port_bus
);

  logic             band_ok;
  logic [BUS_W-1:0] band_code;
  logic             step_last;
  step_e            state;
  logic [BUS_W-1:0] code_q;

  lrp_band_lookup #(.RATE_W(RATE_W), .BUS_W(BUS_W)) u_lookup (
    .rate    (rate_mhz),
    .in_band (band_ok),
    .code    (band_code)
  );

  lrp_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (busy),
    .last (step_last)
  );

  lrp_step_fsm #(.BUS_W(BUS_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .band_ok   (band_ok),
    .band_code (band_code),
    .step_last (step_last),
    .state     (state),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .code_q    (code_q)
  );

  lrp_port_drive #(.BUS_W(BUS_W), .ADDR_CODE(ADDR_CODE)) u_drive (
    .state       (state),
    .code_q      (code_q),
    .p_clr       (port_clr),
    .p_strobe    (port_strobe),
    .p_addr_mode (port_addr_mode),
    .p_bus       (port_bus)
  );

  // R2: while clear is high the rest of the port is quiet
  a_r2_clear_quiet: assert property (@(posedge clk) disable iff (rst)
    port_clr |-> (port_bus == '0 && !port_strobe && !port_addr_mode));

  // R5: a strobe never lasts a single cycle
  a_r5_strobe_width: assert property (@(posedge clk) disable iff (rst)
    $rose(port_strobe) |=> port_strobe);

  // R3: bus held steady while strobe is high
  a_r3_bus_steady: assert property (@(posedge clk) disable iff (rst)
    port_strobe |=> $stable(port_bus));

  // R6: done only closes a busy window
  a_r6_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));

  // R8: a rejection comes with no sequence activity
  a_r8_err_quiet: assert property (@(posedge clk) disable iff (rst)
    err |-> (!busy && !done && !port_strobe && !port_clr));

  // R9: one cycle after reset everything is low
  a_r9_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !done && !err && !port_clr && !port_strobe &&
                    !port_addr_mode && port_bus == '0));

endmodule

// File: tb/lrp_rate_prog_tb.sv
`timescale 1ns/1ps
module lrp_rate_prog_tb;

  localparam int HOLD  = 3;
  localparam int NSTEP = 8;

  typedef struct packed {
    logic [10:0] rate;
    logic [7:0]  code;
    logic        bad;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{11'd80,   8'h00, 1'b0},
    '{11'd89,   8'h00, 1'b0},
    '{11'd90,   8'h20, 1'b0},
    '{11'd109,  8'h40, 1'b0},
    '{11'd110,  8'h02, 1'b0},
    '{11'd124,  8'h02, 1'b0},
    '{11'd125,  8'h22, 1'b0},
    '{11'd199,  8'h44, 1'b0},
    '{11'd359,  8'h2A, 1'b0},
    '{11'd399,  8'h4A, 1'b0},
    '{11'd400,  8'h0C, 1'b0},
    '{11'd449,  8'h0C, 1'b0},
    '{11'd450,  8'h2C, 1'b0},
    '{11'd600,  8'h10, 1'b0},
    '{11'd750,  8'h32, 1'b0},
    '{11'd949,  8'h54, 1'b0},
    '{11'd950,  8'h74, 1'b0},
    '{11'd999,  8'h74, 1'b0},
    '{11'd79,   8'h00, 1'b1},
    '{11'd1000, 8'h00, 1'b1},
    '{11'd0,    8'h00, 1'b1},
    '{11'd2047, 8'h00, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [10:0] rate_i;
  logic        busy, done, err;
  logic        port_clr, port_strobe, port_addr_mode;
  logic [7:0]  port_bus;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  lrp_rate_prog #(.RATE_W(11), .BUS_W(8), .HOLD_CYC(HOLD)) u_dut (
    .clk            (clk),
    .rst            (rst),
    .start          (start),
    .rate_mhz       (rate_i),
    .busy           (busy),
    .done           (done),
    .err            (err),
    .port_clr       (port_clr),
    .port_strobe    (port_strobe),
    .port_addr_mode (port_addr_mode),
    .port_bus       (port_bus)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic bit all_low();
    return !busy && !done && !err && !port_clr && !port_strobe &&
           !port_addr_mode && port_bus == 8'h00;
  endfunction

  // Pulse start with rate r; inj >= 0 injects a start with another rate
  // at that cycle of the sequence.
  task automatic run_seq(input logic [10:0] r, input logic [7:0] code,
                         input bit bad, input int inj);
    int n_busy = 0, n_done = 0, n_err = 0, strobes = 0, clr_cyc = 0;
    int clr_bad = 0, clr_late = 0, quiet_bad = 0, bus_chg = 0;
    int addr_v = -1, data_v = -1, first_mode = -1;
    int run_len = 0, run_min = 999, run_max = 0;
    bit prev_stb = 1'b0;
    logic [7:0] prev_bus = 8'h00;
    @(negedge clk);
    rate_i = r;
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (bad) begin
      chk(err == 1'b1 && busy == 1'b0, $sformatf("R8 err pulse rate=%0d", r),
          {err, busy}, 2'b10);
      for (int c = 0; c < 12; c++) begin
        if (err) n_err++;
        if (busy || done || port_clr || port_strobe || port_addr_mode ||
            port_bus != 8'h00) quiet_bad++;
        @(negedge clk);
      end
      chk(n_err == 1, $sformatf("R8 err single cycle rate=%0d", r), n_err, 1);
      chk(quiet_bad == 0, $sformatf("R8 no port activity rate=%0d", r), quiet_bad, 0);
      return;
    end
    for (int c = 0; c < 80; c++) begin
      if (busy) n_busy++;
      if (done) n_done++;
      if (err)  n_err++;
      if (port_clr) begin
        clr_cyc++;
        if (port_bus != 8'h00 || port_strobe || port_addr_mode) clr_bad++;
        if (strobes > 0) clr_late++;
      end
      if (port_strobe) begin
        if (!prev_stb) begin
          strobes++;
          if (first_mode < 0) first_mode = int'(port_addr_mode);
          if (port_addr_mode) addr_v = int'(port_bus);
          else                data_v = int'(port_bus);
        end else if (port_bus != prev_bus) bus_chg++;
        run_len++;
      end else if (prev_stb) begin
        if (run_len < run_min) run_min = run_len;
        if (run_len > run_max) run_max = run_len;
        run_len = 0;
      end
      prev_stb = port_strobe;
      prev_bus = port_bus;
      if (done) break;
      if (c == inj) begin
        start  = 1'b1;
        rate_i = 11'd999;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(data_v == int'(code), $sformatf("R1/R4 data code rate=%0d", r), data_v, code);
    chk(addr_v == 'h44, $sformatf("R3 address byte rate=%0d", r), addr_v, 'h44);
    chk(first_mode == 1 && strobes == 2,
        $sformatf("R3 address strobe first, two strobes rate=%0d", r),
        strobes * 16 + first_mode, 'h21);
    chk(bus_chg == 0, $sformatf("R3 bus steady under strobe rate=%0d", r), bus_chg, 0);
    chk(clr_cyc == HOLD && clr_bad == 0 && clr_late == 0,
        $sformatf("R2 clear phase rate=%0d", r), clr_cyc, HOLD);
    chk(run_min == HOLD && run_max == HOLD,
        $sformatf("R5 strobe width rate=%0d", r), run_min * 256 + run_max,
        HOLD * 256 + HOLD);
    chk(n_busy == NSTEP * HOLD, $sformatf("R6 busy length rate=%0d", r),
        n_busy, NSTEP * HOLD);
    chk(n_done == 1 && busy == 1'b0 && n_err == 0,
        $sformatf("R6 done pulse rate=%0d", r), n_done, 1);
    quiet_bad = 0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (!all_low()) quiet_bad++;
    end
    chk(quiet_bad == 0, $sformatf("R6/R7 idle after done rate=%0d", r), quiet_bad, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", 100000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst    = 1'b1;
    start  = 1'b0;
    rate_i = 11'd0;
    repeat (3) @(negedge clk);
    chk(all_low(), "R9 reset state", {busy, done, err, port_clr, port_strobe}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(all_low(), "R9 idle after reset release", port_bus, 0);

    // table walk: R1 codes at band edges, R8 rejections
    for (int i = 0; i < NV; i++) begin
      run_seq(VECS[i].rate, VECS[i].code, VECS[i].bad, -1);
    end

    // R7 / R4: start with a new rate mid-sequence is ignored
    run_seq(11'd400, 8'h0C, 1'b0, 7);
    run_seq(11'd150, 8'h04, 1'b0, 2);

    // R7: start accepted in the done cycle
    @(negedge clk);
    rate_i = 11'd300;
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 60; c++) begin
      if (done) break;
      @(negedge clk);
    end
    rate_i = 11'd500;
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1 && port_clr == 1'b1, "R7 restart in done cycle",
        {busy, port_clr}, 2'b11);
    for (int c = 0; c < 60; c++) begin
      if (done) break;
      if (port_strobe && !port_addr_mode) begin
        chk(port_bus == 8'h0E, "R7 restarted code", port_bus, 8'h0E);
        break;
      end
      @(negedge clk);
    end
    for (int c = 0; c < 60; c++) begin
      if (done) break;
      @(negedge clk);
    end
    @(negedge clk);

    // R9: reset during the address phase
    rate_i = 11'd600;
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3 * HOLD) @(negedge clk);
    chk(port_addr_mode == 1'b1, "R9 precondition address phase", port_addr_mode, 1);
    rst = 1'b1;
    @(negedge clk);
    chk(all_low(), "R9 reset mid-sequence", {busy, port_addr_mode, port_bus}, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk(all_low(), "R9 stays idle after reset", {busy, done}, 0);

    // fresh sequence still works after mid-flight reset
    run_seq(11'd820, 8'h14, 1'b0, -1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule